// File: doc/BRIEF.md
# Reaction Game Controller

This block is the core of a single-player reaction game for a small FPGA board. While a round runs, one of four LEDs lights at a time. Which LED lights, and for how long, comes from a free-running 16-bit linear feedback shift register. The LED choice and the on-time are read from bits spread across that register, so a player cannot easily guess the next LED. The player tries to press the button that belongs to the lit LED before it goes dark. Each correct press scores one point and moves the game straight on to a new LED.

A start button begins a round of fixed length, 60 seconds at the default clock. When the round timer runs out, the LEDs go dark. The two-digit decimal score is then shown on a multiplexed seven-segment display until the next start. Every button passes through a synchronizer and a debounce filter inside the block. All timing constants are parameters, so a short round can be used in simulation.

Top module: `reaction_game`

## Requirements
- R1: While reset is held, and after it is released, the game is idle: all LEDs are off, and both digit enables and all segment lines are low.
- R2: At most one LED is lit at any time. While a round runs, every lit period is followed by at least one cycle with all LEDs dark before the next LED lights.
- R3: An LED that is not pressed stays lit for exactly ON_BASE + ON_STEP*k cycles. Here k = {lfsr[9], lfsr[6]} is taken from the register value at the moment the LED is chosen.
- R4: The LFSR is 16 bits wide and shifts left every clock. Its new bit 0 is lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]. It is loaded with 16'hACE1 in every reset cycle, runs between rounds and never holds zero. The chosen LED is ledOut[i] with i = {lfsr[13], lfsr[2]}, taken from the value before the edge at which the LED lights.
- R5: A button counts only when its synchronized level has differed from the accepted level for DEB_CYCLES consecutive cycles. Only a low-to-high change of the accepted level is a press, and a shorter pulse has no effect.
- R6: A press of the lit LED's button adds one to the score, and that LED is dark in the next cycle. A press of any other button gives no point and leaves the lit LED unchanged.
- R7: The score is kept as two BCD digits and saturates at 99.
- R8: A start press in the idle or score-display state begins a round and clears the score. A start press during a round is ignored.
- R9: The display state is entered exactly ROUND_TICKS cycles after the round begins, which is ROUND_TICKS-1 cycles after the first LED lights. In that state all LEDs are off.
- R10: In the display state exactly one digit is enabled: digitEn=2'b01 selects the ones digit and 2'b10 the tens digit. The selection alternates every MUX_CYCLES cycles. segOut is active high with bit 0 = segment a through bit 6 = segment g. Outside the display state, digitEn and segOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startBtn | input | 1 | Raw start button, active high |
| playerBtn | input | 4 | Raw player buttons, one per LED, active high |
| ledOut | output | 4 | LED drives, active high |
| segOut | output | 7 | Seven-segment lines, bit 0 = a ... bit 6 = g, active high |
| digitEn | output | 2 | Digit enables: bit 0 ones, bit 1 tens, active high |

## Verification
The assertions check the following on every cycle:
- at most one LED is lit, and the lit LED is dark right after a hit;
- the LFSR is never zero;
- the score digits stay valid BCD and remain at 99 once there;
- a round timer with time left keeps the game playing, regardless of the start button;
- each debounced press lasts a single cycle;
- the LEDs are dark and exactly one digit is enabled in the display state.

Other properties need whole scenarios, which only the bench can run. These are the exact LED chosen from the register, the exact on-times, that wrong presses and short glitches are ignored, the round length, and the final score shown after a random mix of hits, misses and skipped LEDs, including a round that runs past 99.

// File: rtl/game_pkg.sv
package game_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLAY = 2'd1,
    ST_SHOW = 2'd2
  } game_state_t;

  typedef struct packed {
    logic clearScore;
    logic runGame;
    logic showScore;
  } game_strobe_t;

  // segment order: bit 0 = a ... bit 6 = g, active high
  function automatic logic [6:0] bcdToSeg(input logic [3:0] digit);
    logic [6:0] seg;
    case (digit)
      4'd0: seg = 7'h3F;
      4'd1: seg = 7'h06;
      4'd2: seg = 7'h5B;
      4'd3: seg = 7'h4F;
      4'd4: seg = 7'h66;
      4'd5: seg = 7'h6D;
      4'd6: seg = 7'h7D;
      4'd7: seg = 7'h07;
      4'd8: seg = 7'h7F;
      4'd9: seg = 7'h6F;
      default: seg = 7'h00;
    endcase
    return seg;
  endfunction

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int DEB_CYCLES = 250_000
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic press
);
  localparam int DW = $clog2(DEB_CYCLES + 1);

  logic syncA, syncB, stable, stablePrev;
  logic [DW-1:0] debCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA      <= 1'b0;
      syncB      <= 1'b0;
      stable     <= 1'b0;
      stablePrev <= 1'b0;
      debCnt     <= '0;
    end else begin
      syncA      <= rawIn;
      syncB      <= syncA;
      stablePrev <= stable;
      if (syncB == stable) begin
        debCnt <= '0;
      end else if (debCnt == DW'(DEB_CYCLES - 1)) begin
        stable <= syncB;
        debCnt <= '0;
      end else begin
        debCnt <= debCnt + DW'(1);
      end
    end
  end

  assign press = stable & ~stablePrev;

  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    press |=> !press); // R5

endmodule

// File: rtl/game_ctrl.sv
module game_ctrl
  import game_pkg::*;
#(
  parameter int ROUND_TICKS = 1_500_000_000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         startPress,
  output game_strobe_t strobe
);
  localparam int TW = $clog2(ROUND_TICKS + 1);

  game_state_t   state;
  logic [TW-1:0] roundLeft;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      roundLeft <= '0;
    end else begin
      case (state)
        ST_PLAY: begin
          if (roundLeft == '0) state <= ST_SHOW;
          else roundLeft <= roundLeft - TW'(1);
        end
        default: begin
          if (startPress) begin
            state     <= ST_PLAY;
            roundLeft <= TW'(ROUND_TICKS - 1);
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.clearScore = startPress && (state != ST_PLAY);
    strobe.runGame    = (state == ST_PLAY);
    strobe.showScore  = (state == ST_SHOW);
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    roundLeft <= TW'(ROUND_TICKS - 1)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PLAY && roundLeft != '0) |=> state == ST_PLAY); // R8
  AST_ROUND_END: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PLAY && roundLeft == '0) |=> state == ST_SHOW); // R9

endmodule

// File: rtl/game_datapath.sv
module game_datapath
  import game_pkg::*;
#(
  parameter int          ON_BASE    = 12_500_000,
  parameter int          ON_STEP    = 6_250_000,
  parameter int          MUX_CYCLES = 12_500,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  game_strobe_t strobe,
  input  logic [3:0]   press,
  output logic [3:0]   ledOut,
  output logic [6:0]   segOut,
  output logic [1:0]   digitEn
);
  localparam int ON_W   = $clog2(ON_BASE + 3 * ON_STEP + 1);
  localparam int MW     = $clog2(MUX_CYCLES + 1);
  localparam int IDX_HI = 13;
  localparam int IDX_LO = 2;
  localparam int ON_HI  = 9;
  localparam int ON_LO  = 6;

  logic [15:0]     lfsr;
  logic            lfsrFb;
  logic [1:0]      ledIdx;
  logic            ledActive;
  logic [ON_W-1:0] onCnt;
  logic [3:0]      ledMask;
  logic            hit;
  logic [3:0]      scoreOnes, scoreTens;
  logic            scoreFull;
  logic [MW-1:0]   muxCnt;
  logic            digitSel;

  // pattern source: maximal-length 16-bit register, free running
  assign lfsrFb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk) begin
    if (rst) lfsr <= LFSR_SEED;
    else     lfsr <= {lfsr[14:0], lfsrFb};
  end

  // LED selection and on-time
  assign ledMask = 4'b0001 << ledIdx;
  assign hit     = ledActive && ((press & ledMask) != 4'b0000);

  always_ff @(posedge clk) begin
    if (rst || !strobe.runGame) begin
      ledActive <= 1'b0;
      ledIdx    <= 2'd0;
      onCnt     <= '0;
    end else if (!ledActive) begin
      ledActive <= 1'b1;
      ledIdx    <= {lfsr[IDX_HI], lfsr[IDX_LO]};
      onCnt     <= ON_W'(ON_BASE - 1 + ON_STEP * int'({lfsr[ON_HI], lfsr[ON_LO]}));
    end else if (hit || onCnt == '0) begin
      ledActive <= 1'b0;
    end else begin
      onCnt <= onCnt - ON_W'(1);
    end
  end

  assign ledOut = (strobe.runGame && ledActive) ? ledMask : 4'b0000;

  // two-digit BCD score, saturating
  assign scoreFull = (scoreTens == 4'd9) && (scoreOnes == 4'd9);

  always_ff @(posedge clk) begin
    if (rst || strobe.clearScore) begin
      scoreOnes <= 4'd0;
      scoreTens <= 4'd0;
    end else if (strobe.runGame && hit && !scoreFull) begin
      if (scoreOnes == 4'd9) begin
        scoreOnes <= 4'd0;
        scoreTens <= scoreTens + 4'd1;
      end else begin
        scoreOnes <= scoreOnes + 4'd1;
      end
    end
  end

  // display multiplexing
  always_ff @(posedge clk) begin
    if (rst) begin
      muxCnt   <= '0;
      digitSel <= 1'b0;
    end else if (muxCnt == MW'(MUX_CYCLES - 1)) begin
      muxCnt   <= '0;
      digitSel <= ~digitSel;
    end else begin
      muxCnt <= muxCnt + MW'(1);
    end
  end

  always_comb begin
    if (strobe.showScore) begin
      digitEn = digitSel ? 2'b10 : 2'b01;
      segOut  = bcdToSeg(digitSel ? scoreTens : scoreOnes);
    end else begin
      digitEn = 2'b00;
      segOut  = 7'h00;
    end
  end

  AST_LED_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ledOut)); // R2
  AST_HIT_DARK: assert property (@(posedge clk) disable iff (rst)
    (strobe.runGame && hit) |=> ledOut == 4'b0000); // R6
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lfsr != 16'h0000); // R4
  AST_SCORE_BCD: assert property (@(posedge clk) disable iff (rst)
    scoreOnes <= 4'd9 && scoreTens <= 4'd9); // R7
  AST_SCORE_SAT: assert property (@(posedge clk) disable iff (rst)
    (scoreFull && !strobe.clearScore) |=> scoreFull); // R7
  AST_DARK_SHOW: assert property (@(posedge clk) disable iff (rst)
    strobe.showScore |-> ledOut == 4'b0000); // R9
  AST_DIGIT_SHOW: assert property (@(posedge clk) disable iff (rst)
    strobe.showScore |-> $countones(digitEn) == 1); // R10
  AST_DISPLAY_OFF: assert property (@(posedge clk) disable iff (rst)
    !strobe.showScore |-> (digitEn == 2'b00 && segOut == 7'h00)); // R10

endmodule

// File: rtl/reaction_game.sv
module reaction_game
  import game_pkg::*;
#(
  parameter int          ROUND_TICKS = 1_500_000_000,
  parameter int          DEB_CYCLES  = 250_000,
  parameter int          ON_BASE     = 12_500_000,
  parameter int          ON_STEP     = 6_250_000,
  parameter int          MUX_CYCLES  = 12_500,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startBtn,
  input  logic [3:0] playerBtn,
  output logic [3:0] ledOut,
  output logic [6:0] segOut,
  output logic [1:0] digitEn
);
  localparam int NUM_LEDS = 4;

  logic [NUM_LEDS-1:0] playerPress;
  logic                startPress;
  game_strobe_t        strobe;

  for (genvar b = 0; b < NUM_LEDS; b++) begin : g_player
    btn_conditioner #(.DEB_CYCLES(DEB_CYCLES)) u_cond (
      .clk(clk), .rst(rst), .rawIn(playerBtn[b]), .press(playerPress[b])
    );
  end

  btn_conditioner #(.DEB_CYCLES(DEB_CYCLES)) u_startCond (
    .clk(clk), .rst(rst), .rawIn(startBtn), .press(startPress)
  );

  game_ctrl #(.ROUND_TICKS(ROUND_TICKS)) u_ctrl (
    .clk(clk), .rst(rst), .startPress(startPress), .strobe(strobe)
  );

  game_datapath #(
    .ON_BASE(ON_BASE), .ON_STEP(ON_STEP),
    .MUX_CYCLES(MUX_CYCLES), .LFSR_SEED(LFSR_SEED)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .press(playerPress),
    .ledOut(ledOut), .segOut(segOut), .digitEn(digitEn)
  );

endmodule

// File: tb/tb_reaction_game.sv
module tb_reaction_game;
  localparam int ROUND = 12000;
  localparam int DEB   = 4;
  localparam int MUXC  = 8;
  localparam int ONB   = 32;
  localparam int ONS   = 8;
  localparam int HOLD  = DEB + 6;
  localparam logic [15:0] SEED = 16'hACE1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startBtn = 1'b0;
  logic [3:0] playerBtn = 4'b0000;
  logic [3:0] ledOut;
  logic [6:0] segOut;
  logic [1:0] digitEn;

  always #2 clk = ~clk;

  reaction_game #(
    .ROUND_TICKS(ROUND), .DEB_CYCLES(DEB), .ON_BASE(ONB),
    .ON_STEP(ONS), .MUX_CYCLES(MUXC), .LFSR_SEED(SEED)
  ) dut (
    .clk(clk), .rst(rst), .startBtn(startBtn), .playerBtn(playerBtn),
    .ledOut(ledOut), .segOut(segOut), .digitEn(digitEn)
  );

  int          checks = 0;
  int          failures = 0;
  int          cycleNo = 0;
  int          startCyc = 0;
  int          expOn = 0;
  bit          inRound = 1'b0;
  bit          finished = 1'b0;
  logic [15:0] model = SEED;
  logic [15:0] prevModel = SEED;
  logic [3:0]  prevLed = 4'b0000;

  function automatic logic [15:0] lfsrStep(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int segToDigit(input logic [6:0] s);
    case (s)
      7'h3F: return 0;  7'h06: return 1;  7'h5B: return 2;  7'h4F: return 3;
      7'h66: return 4;  7'h6D: return 5;  7'h7D: return 6;  7'h07: return 7;
      7'h7F: return 8;  7'h6F: return 9;
      default: return -1;
    endcase
  endfunction

  function automatic int ledIndex(input logic [3:0] l);
    for (int i = 0; i < 4; i++) if (l[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // reference LFSR model, sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    cycleNo++;
    prevModel = model;
    model = rst ? SEED : lfsrStep(model);
    if (!rst && prevLed == 4'b0000 && ledOut != 4'b0000) begin
      logic [1:0] expIdx;
      expIdx = {prevModel[13], prevModel[2]};
      check(ledOut == (4'b0001 << expIdx), "R4", "LED chosen from register",
            int'(ledOut), int'(4'b0001 << expIdx));
      expOn = ONB + ONS * int'({prevModel[9], prevModel[6]});
      if (!inRound) begin
        inRound  = 1'b1;
        startCyc = cycleNo;
      end
    end
    prevLed = ledOut;
  end

  initial begin
    #(4 * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycleNo, 0);
    finishRun();
  end

  task automatic pressPlayer(input int idx);
    playerBtn[idx] = 1'b1;
    repeat (HOLD) tick();
    playerBtn[idx] = 1'b0;
    repeat (HOLD) tick();
  endtask

  task automatic pressStart();
    startBtn = 1'b1;
    repeat (HOLD) tick();
    startBtn = 1'b0;
    repeat (HOLD) tick();
  endtask

  task automatic readScore(output int value);
    int ones, tens, run, guard;
    guard = 0;
    while (digitEn != 2'b01 && guard < 100) begin tick(); guard++; end
    ones = segToDigit(segOut);
    while (digitEn != 2'b10 && guard < 200) begin tick(); guard++; end
    tens = segToDigit(segOut);
    while (digitEn != 2'b01 && guard < 300) begin tick(); guard++; end
    run = 0;
    while (digitEn == 2'b01 && run < 100) begin tick(); run++; end
    check(run == MUXC, "R10", "digit dwell cycles", run, MUXC);
    check(digitEn == 2'b10, "R10", "digit alternation", int'(digitEn), 2);
    check(ones >= 0 && tens >= 0, "R10", "valid segment patterns", ones, tens);
    value = tens * 10 + ones;
  endtask

  // mode 0: random mix, mode 1: hit every LED, mode 2: passive
  task automatic playRound(input int mode, output int hits);
    int lit, remaining, r, w, n, ledCount, endCyc, score, expScore;
    bit startTried;
    hits = 0;
    ledCount = 0;
    startTried = 1'b0;
    inRound = 1'b0;
    pressStart();
    while (ledOut != 4'b0000 && digitEn == 2'b00) tick();
    forever begin
      while (ledOut == 4'b0000 && digitEn == 2'b00) tick();
      if (digitEn != 2'b00) break;
      lit = ledIndex(ledOut);
      ledCount++;
      remaining = ROUND - (cycleNo - startCyc);
      if (remaining < 200) begin
        while (ledOut != 4'b0000 && digitEn == 2'b00) tick();
        continue;
      end
      if (mode == 0 && ledCount == 10 && !startTried) begin
        startTried = 1'b1;
        pressStart(); // R8: ignored mid-round, score must survive
        while (ledOut != 4'b0000 && digitEn == 2'b00) tick();
        continue;
      end
      r = (mode == 1) ? 0 : (mode == 2) ? 3 : int'($urandom_range(3, 0));
      if (r <= 1) begin
        repeat (2) tick();
        pressPlayer(lit);
        hits++;
        while (ledOut != 4'b0000 && digitEn == 2'b00) tick();
      end else if (r == 2) begin
        w = (lit + 1 + int'($urandom_range(2, 0))) % 4;
        repeat (2) tick();
        playerBtn[w] = 1'b1;
        repeat (HOLD) tick();
        check(ledOut == (4'b0001 << lit), "R6", "wrong button leaves LED",
              int'(ledOut), int'(4'b0001 << lit));
        playerBtn[w] = 1'b0;
        repeat (HOLD) tick();
        while (ledOut != 4'b0000 && digitEn == 2'b00) tick();
      end else begin
        n = 0;
        while (ledOut == (4'b0001 << lit) && digitEn == 2'b00) begin
          n++;
          tick();
        end
        check(n == expOn, "R3", "LED on-time", n, expOn);
        check(ledOut == 4'b0000, "R2", "dark gap after LED", int'(ledOut), 0);
      end
    end
    endCyc = cycleNo;
    check(endCyc - startCyc == ROUND - 1, "R9", "round length", endCyc - startCyc, ROUND - 1);
    for (int i = 0; i < 20; i++) begin
      if (ledOut != 4'b0000)
        check(1'b0, "R9", "LEDs dark while score shown", int'(ledOut), 0);
      tick();
    end
    check(ledOut == 4'b0000, "R9", "LEDs dark while score shown", int'(ledOut), 0);
    readScore(score);
    expScore = (hits > 99) ? 99 : hits;
    check(score == expScore, (mode == 1) ? "R7" : "R6", "final score", score, expScore);
  endtask

  initial begin
    int hits;
    void'($urandom(32'd4242));
    repeat (5) tick();
    check(ledOut == 4'b0000, "R1", "LEDs off in reset", int'(ledOut), 0);
    check(digitEn == 2'b00 && segOut == 7'h00, "R1", "display off in reset", int'(digitEn), 0);
    rst = 1'b0;
    repeat (10) tick();
    check(ledOut == 4'b0000 && digitEn == 2'b00, "R1", "idle after reset", int'(ledOut), 0);

    // R5: start glitch shorter than the debounce window
    startBtn = 1'b1;
    repeat (2) tick();
    startBtn = 1'b0;
    repeat (40) tick();
    check(ledOut == 4'b0000 && digitEn == 2'b00, "R5", "glitch ignored", int'(ledOut), 0);

    playRound(0, hits);   // random mix, started from idle
    playRound(1, hits);   // every LED hit: R7 saturation
    check(hits > 99, "R7", "enough hits to saturate", hits, 100);
    playRound(2, hits);   // R8: restart from display clears score to 0
    finishRun();
  end

endmodule